// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block turns high-level flash requests into the write-cycle sequences that an asynchronous parallel NOR device expects. A requester presents an operation code with a target address and a data word; the sequencer walks the matching list of unlock and command writes, then the data write where one is needed. Each write is a timed strobe on the flash bus. Completion is signalled by a one-clock `done` pulse. For program and erase operations, a separate status poller is started by a one-clock `poll_start` pulse.

The sequencer remembers whether the device has been placed in its fast-program (unlock-bypass) state. While that state is active, a word program needs only one command write before the data write. A whole-chip erase is refused while it is active. The two unlock addresses and the chip base address are parameters. The high-voltage programming enable is held for the full length of every program or erase. After the data write of a program, a configurable word-write delay elapses before completion is signalled.

Top module: `nor_cmd_seq`

## Requirements
- R1: Out of reset the block is idle with `req_ready`=1 and `flash_ce_n`, `flash_we_n` and `flash_oe_n` all 1. `vpp_enable`, `done`, `poll_start`, `rejected` and `bypass_active` are all 0.
- R2: A program request (op code 1) with bypass inactive issues four writes in this order: 0x00AA to UNLOCK1_ADDR, 0x0055 to UNLOCK2_ADDR, 0x00A0 to UNLOCK1_ADDR, then the request data to the request address. Command bytes sit in bits 7:0 and the upper data bits are zero.
- R3: A program request with bypass active issues two writes: 0x00A0 to BASE_ADDR, then the request data to the request address.
- R4: A bypass-enter request (op code 3) issues 0x00AA to UNLOCK1_ADDR, then 0x0055 to UNLOCK2_ADDR, then 0x0020 to UNLOCK1_ADDR. `bypass_active` reads 1 from the clock after its `done`.
- R5: A bypass-exit request (op code 4) issues 0x0090 and then 0x0000, both to BASE_ADDR. `bypass_active` reads 0 from the clock after its `done`.
- R6: A chip-erase request (op code 2) with bypass inactive issues six writes: 0x00AA, 0x0055, 0x0080, 0x00AA, 0x0055, 0x0010. Their addresses are UNLOCK1, UNLOCK2, UNLOCK1, UNLOCK1, UNLOCK2, UNLOCK1 in that order.
- R7: A reset request (op code 5) issues one write of 0x00F0 to BASE_ADDR and leaves `bypass_active` unchanged.
- R8: A chip-erase request while bypass is active, or any op code outside 1 to 5, is refused. `rejected` is 1 for exactly the clock after acceptance, no bus write occurs, and `bypass_active` is unchanged.
- R9: Each write drives its address and data for one clock with the strobes high. `flash_ce_n` and `flash_we_n` are then low for exactly STROBE_CLKS clocks with address and data held. Address and data stay held for one further clock with the strobes high. `flash_oe_n` stays 1 throughout.
- R10: After the hold clock of a program's data write, WW_DELAY clocks elapse before `done`. For every other operation, `done` follows the last hold clock directly.
- R11: `vpp_enable` is 1 from the clock after a program or erase is accepted through its `done` clock, and 0 otherwise. It stays 0 for bypass enter, bypass exit and reset.
- R12: `done` is a one-clock pulse ending every accepted operation. `poll_start` pulses together with `done` for program and erase only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is 1 |
| req_op | input | 3 | Operation: 1 program, 2 chip erase, 3 bypass enter, 4 bypass exit, 5 reset |
| req_addr | input | ADDR_W | Target word address for a program |
| req_data | input | DATA_W | Word to program |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| rejected | output | 1 | One-clock pulse for a refused request |
| done | output | 1 | One-clock pulse at the end of an operation |
| poll_start | output | 1 | One-clock pulse telling the status poller to begin |
| bypass_active | output | 1 | Device is in fast-program mode |
| vpp_enable | output | 1 | Programming voltage enable |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_dq_out | output | DATA_W | Flash write data |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |

## Verification
Latency is fixed and data independent. The first write's setup clock comes two clocks after the accepting edge. Each write then takes STROBE_CLKS+3 clocks, counting its issue clock. `done` arrives one clock after the final hold clock, or WW_DELAY+1 clocks after it for a program. A refusal shows as `rejected` in the single clock after acceptance. The bench expands each request into a per-clock list of expected strobe, bus, enable and pulse values and compares one entry at every falling edge. A shifted strobe, a missing write or a late pulse therefore mismatches at the exact clock where it happens. The mode flag is compared in the idle clock that follows each operation.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PROG    = 3'd1,
    OP_ERASE   = 3'd2,
    OP_BYP_ON  = 3'd3,
    OP_BYP_OFF = 3'd4,
    OP_RESET   = 3'd5,
    OP_RSV6    = 3'd6,
    OP_RSV7    = 3'd7
  } nor_op_e;

  typedef enum logic [1:0] {
    ASEL_UNLK1 = 2'd0,
    ASEL_UNLK2 = 2'd1,
    ASEL_BASE  = 2'd2,
    ASEL_TGT   = 2'd3
  } asel_e;

  typedef struct packed {
    asel_e      asel;
    logic       use_datum;
    logic [7:0] cmd;
    logic       last;
  } step_t;

  localparam int STEP_IDX_W = 3;

  localparam logic [7:0] CMD_UNLK_A  = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B  = 8'h55;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERASE0  = 8'h80;
  localparam logic [7:0] CMD_ERASE1  = 8'h10;
  localparam logic [7:0] CMD_BYP_ON  = 8'h20;
  localparam logic [7:0] CMD_BYP_X0  = 8'h90;
  localparam logic [7:0] CMD_BYP_X1  = 8'h00;
  localparam logic [7:0] CMD_RESET   = 8'hF0;

endpackage

// File: rtl/nor_seq_table.sv
module nor_seq_table
  import nor_seq_pkg::*;
(
  input  nor_op_e               op,
  input  logic                  bypass,
  input  logic [STEP_IDX_W-1:0] idx,
  output step_t                 step
);

  function automatic step_t mk(input asel_e a, input logic dat, input logic [7:0] c,
                               input logic lst);
    step_t s;
    s.asel      = a;
    s.use_datum = dat;
    s.cmd       = c;
    s.last      = lst;
    return s;
  endfunction

  always_comb begin
    step = mk(ASEL_BASE, 1'b0, CMD_RESET, 1'b1);
    unique case (op)
      OP_PROG: begin
        if (bypass) begin
          case (idx)
            3'd0:    step = mk(ASEL_BASE, 1'b0, CMD_PROG, 1'b0);
            default: step = mk(ASEL_TGT, 1'b1, 8'h00, 1'b1);
          endcase
        end else begin
          case (idx)
            3'd0:    step = mk(ASEL_UNLK1, 1'b0, CMD_UNLK_A, 1'b0);
            3'd1:    step = mk(ASEL_UNLK2, 1'b0, CMD_UNLK_B, 1'b0);
            3'd2:    step = mk(ASEL_UNLK1, 1'b0, CMD_PROG, 1'b0);
            default: step = mk(ASEL_TGT, 1'b1, 8'h00, 1'b1);
          endcase
        end
      end
      OP_ERASE: begin
        case (idx)
          3'd0:    step = mk(ASEL_UNLK1, 1'b0, CMD_UNLK_A, 1'b0);
          3'd1:    step = mk(ASEL_UNLK2, 1'b0, CMD_UNLK_B, 1'b0);
          3'd2:    step = mk(ASEL_UNLK1, 1'b0, CMD_ERASE0, 1'b0);
          3'd3:    step = mk(ASEL_UNLK1, 1'b0, CMD_UNLK_A, 1'b0);
          3'd4:    step = mk(ASEL_UNLK2, 1'b0, CMD_UNLK_B, 1'b0);
          default: step = mk(ASEL_UNLK1, 1'b0, CMD_ERASE1, 1'b1);
        endcase
      end
      OP_BYP_ON: begin
        case (idx)
          3'd0:    step = mk(ASEL_UNLK1, 1'b0, CMD_UNLK_A, 1'b0);
          3'd1:    step = mk(ASEL_UNLK2, 1'b0, CMD_UNLK_B, 1'b0);
          default: step = mk(ASEL_UNLK1, 1'b0, CMD_BYP_ON, 1'b1);
        endcase
      end
      OP_BYP_OFF: begin
        case (idx)
          3'd0:    step = mk(ASEL_BASE, 1'b0, CMD_BYP_X0, 1'b0);
          default: step = mk(ASEL_BASE, 1'b0, CMD_BYP_X1, 1'b1);
        endcase
      end
      default: step = mk(ASEL_BASE, 1'b0, CMD_RESET, 1'b1);
    endcase
  end

endmodule

// File: rtl/nor_bus_engine.sv
module nor_bus_engine #(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int STROBE_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              cycle_done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n
);

  localparam int CNT_W = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CLKS - 1);

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_HOLD} bstate_e;

  bstate_e            st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic               ce_q, we_q;
  logic               ld_bus;

  assign ld_bus = go && (st_q == B_IDLE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      B_IDLE:   if (go) st_d = B_SETUP;
      B_SETUP: begin
        st_d  = B_STROBE;
        cnt_d = CNT_LOAD;
      end
      B_STROBE: begin
        if (cnt_q == '0) st_d = B_HOLD;
        else             cnt_d = cnt_q - 1'b1;
      end
      default:  st_d = B_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= B_IDLE;
      cnt_q <= '0;
      ce_q  <= 1'b1;
      we_q  <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ce_q  <= (st_d != B_STROBE);
      we_q  <= (st_d != B_STROBE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (ld_bus) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

  assign cycle_done = (st_q == B_HOLD);
  assign bus_addr   = addr_q;
  assign bus_data   = data_q;
  assign ce_n       = ce_q;
  assign we_n       = we_q;
  assign oe_n       = 1'b1;

endmodule

// File: rtl/nor_wait_timer.sv
module nor_wait_timer #(
  parameter int DELAY_CLKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic fire
);

  localparam int TW = $clog2(DELAY_CLKS + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(DELAY_CLKS);
  localparam logic [TW-1:0] T_ONE  = TW'(1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = T_LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fire = (cnt_q == T_ONE);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int                ADDR_W       = 20,
  parameter int                DATA_W       = 16,
  parameter int                STROBE_CLKS  = 3,
  parameter int                WW_DELAY     = 50,
  parameter logic [ADDR_W-1:0] UNLOCK1_ADDR = 'h555,
  parameter logic [ADDR_W-1:0] UNLOCK2_ADDR = 'h2AA,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              rejected,
  output logic              done,
  output logic              poll_start,
  output logic              bypass_active,
  output logic              vpp_enable,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0] flash_dq_out,
  output logic              flash_ce_n,
  output logic              flash_we_n,
  output logic              flash_oe_n
);

  localparam int PAD_W = DATA_W - 8;

  typedef enum logic [2:0] {C_IDLE, C_ISSUE, C_WAIT, C_DELAY, C_FINISH} cstate_e;

  cstate_e               st_q, st_d;
  nor_op_e               op_q, op_d, req_op_e;
  logic [ADDR_W-1:0]     tgt_q, tgt_d;
  logic [DATA_W-1:0]     dat_q, dat_d;
  logic [STEP_IDX_W-1:0] idx_q, idx_d;
  logic                  byp_q, byp_d;
  logic                  vpp_q, vpp_d;
  logic                  rej_q, rej_d;

  logic                  take, op_known, refuse, needs_vpp_req;
  logic                  go, cyc_done, tmr_start, tmr_fire;
  step_t                 step;
  logic [ADDR_W-1:0]     step_addr;
  logic [DATA_W-1:0]     step_data;

  assign req_op_e      = nor_op_e'(req_op);
  assign take          = req_valid && (st_q == C_IDLE);
  assign op_known      = (req_op_e == OP_PROG) || (req_op_e == OP_ERASE) ||
                         (req_op_e == OP_BYP_ON) || (req_op_e == OP_BYP_OFF) ||
                         (req_op_e == OP_RESET);
  assign refuse        = !op_known || ((req_op_e == OP_ERASE) && byp_q);
  assign needs_vpp_req = (req_op_e == OP_PROG) || (req_op_e == OP_ERASE);

  nor_seq_table u_table (
    .op     (op_q),
    .bypass (byp_q),
    .idx    (idx_q),
    .step   (step)
  );

  always_comb begin
    unique case (step.asel)
      ASEL_UNLK1: step_addr = UNLOCK1_ADDR;
      ASEL_UNLK2: step_addr = UNLOCK2_ADDR;
      ASEL_BASE:  step_addr = BASE_ADDR;
      default:    step_addr = tgt_q;
    endcase
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign step_data = step.use_datum ? dat_q : {{PAD_W{1'b0}}, step.cmd};
    end else begin : g_nopad
      assign step_data = step.use_datum ? dat_q : step.cmd[DATA_W-1:0];
    end
  endgenerate

  assign go = (st_q == C_ISSUE);

  nor_bus_engine #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STROBE_CLKS (STROBE_CLKS)
  ) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .addr_in    (step_addr),
    .data_in    (step_data),
    .cycle_done (cyc_done),
    .bus_addr   (flash_addr),
    .bus_data   (flash_dq_out),
    .ce_n       (flash_ce_n),
    .we_n       (flash_we_n),
    .oe_n       (flash_oe_n)
  );

  assign tmr_start = (st_q == C_WAIT) && cyc_done && step.last && (op_q == OP_PROG);

  nor_wait_timer #(
    .DELAY_CLKS (WW_DELAY)
  ) u_wwt (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .fire  (tmr_fire)
  );

  always_comb begin
    st_d  = st_q;
    op_d  = op_q;
    tgt_d = tgt_q;
    dat_d = dat_q;
    idx_d = idx_q;
    byp_d = byp_q;
    vpp_d = vpp_q;
    rej_d = 1'b0;
    unique case (st_q)
      C_IDLE: begin
        if (take) begin
          if (refuse) begin
            rej_d = 1'b1;
          end else begin
            st_d  = C_ISSUE;
            op_d  = req_op_e;
            tgt_d = req_addr;
            dat_d = req_data;
            idx_d = '0;
            vpp_d = needs_vpp_req;
          end
        end
      end
      C_ISSUE: st_d = C_WAIT;
      C_WAIT: begin
        if (cyc_done) begin
          if (!step.last) begin
            idx_d = idx_q + 1'b1;
            st_d  = C_ISSUE;
          end else if (op_q == OP_PROG) begin
            st_d = C_DELAY;
          end else begin
            st_d = C_FINISH;
          end
        end
      end
      C_DELAY: if (tmr_fire) st_d = C_FINISH;
      default: begin
        st_d  = C_IDLE;
        vpp_d = 1'b0;
        if (op_q == OP_BYP_ON)  byp_d = 1'b1;
        if (op_q == OP_BYP_OFF) byp_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= C_IDLE;
      op_q  <= OP_NONE;
      tgt_q <= '0;
      dat_q <= '0;
      idx_q <= '0;
      byp_q <= 1'b0;
      vpp_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      op_q  <= op_d;
      tgt_q <= tgt_d;
      dat_q <= dat_d;
      idx_q <= idx_d;
      byp_q <= byp_d;
      vpp_q <= vpp_d;
      rej_q <= rej_d;
    end
  end

  assign req_ready     = (st_q == C_IDLE);
  assign rejected      = rej_q;
  assign done          = (st_q == C_FINISH);
  assign poll_start    = (st_q == C_FINISH) && ((op_q == OP_PROG) || (op_q == OP_ERASE));
  assign bypass_active = byp_q;
  assign vpp_enable    = vpp_q;

endmodule

// File: rtl/nor_cmd_seq_checker.sv
module nor_cmd_seq_checker #(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int STROBE_CLKS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic              req_ready,
  input logic              rejected,
  input logic              done,
  input logic              poll_start,
  input logic              bypass_active,
  input logic              vpp_enable,
  input logic [ADDR_W-1:0] flash_addr,
  input logic [DATA_W-1:0] flash_dq_out,
  input logic              flash_ce_n,
  input logic              flash_we_n,
  input logic              flash_oe_n
);

  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           low_run <= '0;
    else if (!flash_ce_n) low_run <= low_run + 1'b1;
    else                  low_run <= '0;
  end

  // R9: strobe width
  assert_strobe_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_ce_n) |-> (low_run == 16'(STROBE_CLKS)));

  // R9: address and data settled one clock before the strobe
  assert_setup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_ce_n) |-> ($stable(flash_addr) && $stable(flash_dq_out)));

  // R9: held through the strobe and one clock after
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_ce_n |=> ($stable(flash_addr) && $stable(flash_dq_out)));

  // R9: output enable never overlaps a write
  assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |-> flash_oe_n);

  // R8: erase refused while in bypass
  assert_erase_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_op == 3'd2) && bypass_active)
      |=> (rejected && req_ready && flash_ce_n && bypass_active));

  // R11: programming voltage drops only after completion
  assert_vpp_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vpp_enable) |-> $past(done));

  // R12: single-clock completion
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: poller kick accompanies completion
  assert_poll_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    poll_start |-> (done && vpp_enable));

endmodule

bind nor_cmd_seq nor_cmd_seq_checker #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .STROBE_CLKS (STROBE_CLKS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_op        (req_op),
  .req_ready     (req_ready),
  .rejected      (rejected),
  .done          (done),
  .poll_start    (poll_start),
  .bypass_active (bypass_active),
  .vpp_enable    (vpp_enable),
  .flash_addr    (flash_addr),
  .flash_dq_out  (flash_dq_out),
  .flash_ce_n    (flash_ce_n),
  .flash_we_n    (flash_we_n),
  .flash_oe_n    (flash_oe_n)
);

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;

  localparam int          AW = 20;
  localparam int          DW = 16;
  localparam int          SC = 2;
  localparam int          WD = 5;
  localparam logic [AW-1:0] U1 = 20'h00555;
  localparam logic [AW-1:0] U2 = 20'h002AA;
  localparam logic [AW-1:0] BA = 20'h40000;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          req_ready, rejected, done, poll_start, bypass_active, vpp_enable;
  logic [AW-1:0] flash_addr;
  logic [DW-1:0] flash_dq_out;
  logic          flash_ce_n, flash_we_n, flash_oe_n;

  int checks = 0;
  int fails  = 0;
  logic exp_byp = 1'b0;

  typedef struct {
    logic          ce_n;
    logic          chk_ad;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          vpp;
    logic          dn;
    logic          poll;
    logic          rej;
    logic          rdy;
    int            tag;
  } exp_t;

  exp_t exp_q[$];

  nor_cmd_seq #(
    .ADDR_W (AW), .DATA_W (DW), .STROBE_CLKS (SC), .WW_DELAY (WD),
    .UNLOCK1_ADDR (U1), .UNLOCK2_ADDR (U2), .BASE_ADDR (BA)
  ) uut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
    .req_addr (req_addr), .req_data (req_data), .req_ready (req_ready),
    .rejected (rejected), .done (done), .poll_start (poll_start),
    .bypass_active (bypass_active), .vpp_enable (vpp_enable),
    .flash_addr (flash_addr), .flash_dq_out (flash_dq_out),
    .flash_ce_n (flash_ce_n), .flash_we_n (flash_we_n), .flash_oe_n (flash_oe_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input int tag, input string what, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h t=%0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic exp_t rec(input logic ce, input logic ad, input logic [AW-1:0] a,
                               input logic [DW-1:0] d, input logic v, input int tag);
    exp_t r;
    r.ce_n = ce; r.chk_ad = ad; r.a = a; r.d = d; r.vpp = v;
    r.dn = 1'b0; r.poll = 1'b0; r.rej = 1'b0; r.rdy = 1'b0; r.tag = tag;
    return r;
  endfunction

  // one bus write: issue, setup, SC strobe clocks, hold
  task automatic add_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic v, input int tag);
    exp_q.push_back(rec(1'b1, 1'b0, a, d, v, tag));
    exp_q.push_back(rec(1'b1, 1'b1, a, d, v, 9));
    for (int i = 0; i < SC; i++) exp_q.push_back(rec(1'b0, 1'b1, a, d, v, 9));
    exp_q.push_back(rec(1'b1, 1'b1, a, d, v, 9));
  endtask

  task automatic add_finish(input logic v, input logic with_delay);
    exp_t r;
    if (with_delay)
      for (int i = 0; i < WD; i++) exp_q.push_back(rec(1'b1, 1'b0, '0, '0, v, 10));
    r = rec(1'b1, 1'b0, '0, '0, v, 12);
    r.dn = 1'b1; r.poll = v;
    exp_q.push_back(r);
  endtask

  task automatic compare(input exp_t r);
    chk(9, "ce_n", {31'd0, flash_ce_n}, {31'd0, r.ce_n});
    chk(9, "we_n", {31'd0, flash_we_n}, {31'd0, r.ce_n});
    chk(9, "oe_n", {31'd0, flash_oe_n}, 32'd1);
    chk(11, "vpp", {31'd0, vpp_enable}, {31'd0, r.vpp});
    chk(12, "done", {31'd0, done}, {31'd0, r.dn});
    chk(12, "poll", {31'd0, poll_start}, {31'd0, r.poll});
    chk(8, "rejected", {31'd0, rejected}, {31'd0, r.rej});
    chk(r.tag, "ready", {31'd0, req_ready}, {31'd0, r.rdy});
    if (r.chk_ad) begin
      chk(r.tag, "addr", {12'd0, flash_addr}, {12'd0, r.a});
      chk(r.tag, "data", {16'd0, flash_dq_out}, {16'd0, r.d});
    end
  endtask

  task automatic check_idle(input int tag);
    chk(tag, "idle ready", {31'd0, req_ready}, 32'd1);
    chk(tag, "idle ce_n", {31'd0, flash_ce_n}, 32'd1);
    chk(tag, "idle vpp", {31'd0, vpp_enable}, 32'd0);
    chk(tag, "idle done", {31'd0, done}, 32'd0);
    chk(tag, "bypass flag", {31'd0, bypass_active}, {31'd0, exp_byp});
  endtask

  // called at a falling edge; returns at the falling edge after the operation
  task automatic run_req(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input int tag);
    exp_t r;
    exp_q.delete();
    if (op == 3'd1) begin
      if (exp_byp) begin
        add_write(BA, 16'h00A0, 1'b1, 3);             // R3
        add_write(a, d, 1'b1, 3);
      end else begin
        add_write(U1, 16'h00AA, 1'b1, 2);             // R2
        add_write(U2, 16'h0055, 1'b1, 2);
        add_write(U1, 16'h00A0, 1'b1, 2);
        add_write(a, d, 1'b1, 2);
      end
      add_finish(1'b1, 1'b1);
    end else if (op == 3'd2 && !exp_byp) begin
      add_write(U1, 16'h00AA, 1'b1, 6);               // R6
      add_write(U2, 16'h0055, 1'b1, 6);
      add_write(U1, 16'h0080, 1'b1, 6);
      add_write(U1, 16'h00AA, 1'b1, 6);
      add_write(U2, 16'h0055, 1'b1, 6);
      add_write(U1, 16'h0010, 1'b1, 6);
      add_finish(1'b1, 1'b0);
    end else if (op == 3'd3) begin
      add_write(U1, 16'h00AA, 1'b0, 4);               // R4
      add_write(U2, 16'h0055, 1'b0, 4);
      add_write(U1, 16'h0020, 1'b0, 4);
      add_finish(1'b0, 1'b0);
    end else if (op == 3'd4) begin
      add_write(BA, 16'h0090, 1'b0, 5);               // R5
      add_write(BA, 16'h0000, 1'b0, 5);
      add_finish(1'b0, 1'b0);
    end else if (op == 3'd5) begin
      add_write(BA, 16'h00F0, 1'b0, 7);               // R7
      add_finish(1'b0, 1'b0);
    end else begin
      r = rec(1'b1, 1'b0, '0, '0, 1'b0, 8);           // R8 refusal
      r.rej = 1'b1; r.rdy = 1'b1;
      exp_q.push_back(r);
    end
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() > 0) begin
      r = exp_q.pop_front();
      compare(r);
      @(negedge clk);
    end
    if (op == 3'd3) exp_byp = 1'b1;
    if (op == 3'd4) exp_byp = 1'b0;
    check_idle(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(1, "ready", {31'd0, req_ready}, 32'd1);
    chk(1, "ce_n", {31'd0, flash_ce_n}, 32'd1);
    chk(1, "we_n", {31'd0, flash_we_n}, 32'd1);
    chk(1, "oe_n", {31'd0, flash_oe_n}, 32'd1);
    chk(1, "outs", {27'd0, vpp_enable, done, poll_start, rejected, bypass_active}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle(1);

    run_req(3'd1, 20'h01234, 16'hBEEF, 2);   // R2 normal program
    run_req(3'd1, 20'hFFFFF, 16'h0000, 2);   // R2 top address, zero data
    run_req(3'd2, 20'h0, 16'h0, 6);          // R6 erase
    run_req(3'd5, 20'h0, 16'h0, 7);          // R7 reset op, bypass off
    run_req(3'd3, 20'h0, 16'h0, 4);          // R4 enter bypass
    run_req(3'd1, 20'h00ABC, 16'h5A5A, 3);   // R3 bypass program
    run_req(3'd1, 20'h00ABD, 16'hFFFF, 3);   // R3 second bypass program
    run_req(3'd2, 20'h0, 16'h0, 8);          // R8 erase refused in bypass
    run_req(3'd5, 20'h0, 16'h0, 7);          // R7 reset op keeps bypass
    run_req(3'd4, 20'h0, 16'h0, 5);          // R5 exit bypass
    run_req(3'd7, 20'h0, 16'h0, 8);          // R8 unknown op
    run_req(3'd0, 20'h0, 16'h0, 8);          // R8 op code zero
    run_req(3'd1, 20'h00100, 16'h1357, 10);  // R10 program back in normal mode
    run_req(3'd2, 20'h0, 16'h0, 11);         // R11 erase after exit

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule